// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address for a small 8-bit processor core once the instruction bytes after the opcode have been fetched. The core presents an addressing-mode code, the unsigned 8-bit index register and up to two operand bytes, then pulses `start`. One clock later the block drives the effective address, the instruction length in bytes and a one-cycle `valid` strobe.

Four modes are covered. In page-zero direct mode, the first operand byte is the address. In bare indexed mode, the index register is the address. In short-offset indexed mode, the index register and the first operand byte are added as two unsigned bytes, so the address can reach 0x1FE. In long-offset indexed mode, the zero-extended index is added to a 16-bit offset, and the sum wraps within the 64 KB space.

The controller has two states. `ST_IDLE` means no result is being announced. `ST_EMIT` means the result registers were loaded on the previous edge and `valid` is high. The transition idle→emit and the transition emit→emit both happen on `start`. The transition emit→idle and the transition idle→idle both happen when `start` is low. The result registers load only on `start` and hold their value at all other times.

Top module: `eam_top`

## Requirements
- R1: Mode code 0 (page-zero direct) gives ea = {8'h00, opnd0} and ilen = 2.
- R2: Mode code 1 (bare indexed) gives ea = {8'h00, index_reg} and ilen = 1.
- R3: Mode code 2 (short-offset indexed) gives ea = index_reg + opnd0 as an unsigned 9-bit sum, at most 0x1FE, and ilen = 2.
- R4: Mode code 3 (long-offset indexed) gives ea = {opnd0, opnd1} + {8'h00, index_reg}, where opnd0 is the high byte, and ilen = 3.
- R5: In mode 3, a sum above 0xFFFF wraps modulo 65536.
- R6: `valid` is high in exactly the cycle after each cycle in which `start` is sampled high, and is low in every other cycle. Back-to-back starts keep `valid` high continuously.
- R7: When `start` is low, `ea` and `ilen` keep their previous values, whatever happens on the other inputs.
- R8: While reset is active and after it is released, `valid`, `ea` and `ilen` read 0 until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Compute request; inputs are sampled in this cycle |
| mode | input | 2 | Addressing mode code, 0 to 3 |
| index_reg | input | 8 | Unsigned index register value |
| opnd0 | input | 8 | First byte after the opcode |
| opnd1 | input | 8 | Second byte after the opcode |
| ea | output | 16 | Registered effective address |
| ilen | output | 2 | Registered instruction length in bytes |
| valid | output | 1 | High for one cycle per start |

## Verification
The hardest case to reach is the carry out of bit 15 in long-offset mode. A wrap happens only when a high offset meets a nonzero index. The stimulus reaches it on purpose with offset 0xFFFF plus index 0xFF, which gives 0x00FE, and with offset 0xFF01 plus index 0xFF, which gives 0x0000. The same directed tests also reach the largest short-offset sum, 0xFF + 0xFF = 0x1FE. They also issue back-to-back starts and check that `valid` stays high and that each result replaces the previous one.

// File: rtl/eam_pkg.sv
package eam_pkg;
    typedef enum logic [1:0] {
        AM_DIR = 2'd0,
        AM_IX0 = 2'd1,
        AM_IX1 = 2'd2,
        AM_IX2 = 2'd3
    } am_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/eam_operand_sel.sv
module eam_operand_sel #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  eam_pkg::am_mode_e  mode,
    input  logic [BYTE_W-1:0]  index_reg,
    input  logic [BYTE_W-1:0]  opnd0,
    input  logic [BYTE_W-1:0]  opnd1,
    output logic [ADDR_W-1:0]  base,
    output logic [ADDR_W-1:0]  addend
);
    import eam_pkg::*;

    localparam int PAD_W = ADDR_W - BYTE_W;
    localparam int HI_PAD = ADDR_W - 2 * BYTE_W;

    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] op0_ext;
    logic [ADDR_W-1:0] wide_off;

    assign idx_ext = {{PAD_W{1'b0}}, index_reg};
    assign op0_ext = {{PAD_W{1'b0}}, opnd0};

    generate
        if (HI_PAD > 0) begin : g_pad
            assign wide_off = {{HI_PAD{1'b0}}, opnd0, opnd1};
        end else begin : g_nopad
            assign wide_off = {opnd0, opnd1};
        end
    endgenerate

    // The base is the offset part of the address, and the addend is the
    // index part. Modes without an index contribution add zero.
    always_comb begin
        unique case (mode)
            AM_DIR: begin base = op0_ext;  addend = '0;      end
            AM_IX0: begin base = '0;       addend = idx_ext; end
            AM_IX1: begin base = op0_ext;  addend = idx_ext; end
            AM_IX2: begin base = wide_off; addend = idx_ext; end
            default: begin base = '0;      addend = '0;      end
        endcase
    end
endmodule

// File: rtl/eam_adder.sv
module eam_adder #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic [ADDR_W-1:0] sum
);
    // The carry out of the top bit is dropped, so the sum wraps modulo 2**ADDR_W.
    logic [ADDR_W:0] full;
    assign full = {1'b0, a} + {1'b0, b};
    assign sum  = full[ADDR_W-1:0];
endmodule

// File: rtl/eam_len_dec.sv
module eam_len_dec #(
    parameter int LEN_W = 2
) (
    input  eam_pkg::am_mode_e mode,
    output logic [LEN_W-1:0]  ilen
);
    import eam_pkg::*;

    always_comb begin
        unique case (mode)
            AM_DIR:  ilen = LEN_W'(2);
            AM_IX0:  ilen = LEN_W'(1);
            AM_IX1:  ilen = LEN_W'(2);
            AM_IX2:  ilen = LEN_W'(3);
            default: ilen = '0;
        endcase
    end
endmodule

// File: rtl/eam_top.sv
module eam_top #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [BYTE_W-1:0] index_reg,
    input  logic [BYTE_W-1:0] opnd0,
    input  logic [BYTE_W-1:0] opnd1,
    output logic [ADDR_W-1:0] ea,
    output logic [LEN_W-1:0]  ilen,
    output logic              valid
);
    import eam_pkg::*;

    am_mode_e          mode_e;
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] addend_w;
    logic [ADDR_W-1:0] sum_w;
    logic [LEN_W-1:0]  len_w;
    ctl_state_e        state_q;
    ctl_state_e        state_d;
    logic [ADDR_W-1:0] ea_q;
    logic [LEN_W-1:0]  ilen_q;

    assign mode_e = am_mode_e'(mode);

    eam_operand_sel #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_sel (
        .mode      (mode_e),
        .index_reg (index_reg),
        .opnd0     (opnd0),
        .opnd1     (opnd1),
        .base      (base_w),
        .addend    (addend_w)
    );

    eam_adder #(.ADDR_W(ADDR_W)) u_add (
        .a   (base_w),
        .b   (addend_w),
        .sum (sum_w)
    );

    eam_len_dec #(.LEN_W(LEN_W)) u_len (
        .mode (mode_e),
        .ilen (len_w)
    );

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = start ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers: they load on start and hold their value otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q   <= '0;
            ilen_q <= '0;
        end else if (start) begin
            ea_q   <= sum_w;
            ilen_q <= len_w;
        end
    end

    assign ea    = ea_q;
    assign ilen  = ilen_q;
    assign valid = (state_q == ST_EMIT);
endmodule

// File: rtl/eam_checker.sv
module eam_checker #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        mode,
    input logic [BYTE_W-1:0] index_reg,
    input logic [BYTE_W-1:0] opnd0,
    input logic [BYTE_W-1:0] opnd1,
    input logic [ADDR_W-1:0] ea,
    input logic [LEN_W-1:0]  ilen,
    input logic              valid
);
    localparam int PAD_W = ADDR_W - BYTE_W;

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(ea) && $stable(ilen)));

    assert_direct_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 2'd0) |=> (ea == {{PAD_W{1'b0}}, $past(opnd0)} && ilen == LEN_W'(2)));

    assert_bare_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 2'd1) |=> (ea == {{PAD_W{1'b0}}, $past(index_reg)} && ilen == LEN_W'(1)));

    assert_short_reach_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 2'd2) |=> (ea <= ADDR_W'(16'h01FE) && ilen == LEN_W'(2)));

    assert_long_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 2'd3) |=> (ilen == LEN_W'(3)));
endmodule

bind eam_top eam_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eam_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .index_reg (index_reg),
    .opnd0     (opnd0),
    .opnd1     (opnd1),
    .ea        (ea),
    .ilen      (ilen),
    .valid     (valid)
);

// File: tb/tb_eam_top.sv
module tb_eam_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [7:0]  index_reg = 8'h00;
    logic [7:0]  opnd0 = 8'h00;
    logic [7:0]  opnd1 = 8'h00;
    logic [15:0] ea;
    logic [1:0]  ilen;
    logic        valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eam_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .index_reg(index_reg), .opnd0(opnd0), .opnd1(opnd1),
        .ea(ea), .ilen(ilen), .valid(valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_ea(input logic [1:0] m, input logic [7:0] x,
                                             input logic [7:0] b0, input logic [7:0] b1);
        case (m)
            2'd0:    return {8'h00, b0};
            2'd1:    return {8'h00, x};
            2'd2:    return 16'({8'h00, x} + {8'h00, b0});
            default: return 16'({b0, b1} + {8'h00, x});
        endcase
    endfunction

    function automatic logic [1:0] model_len(input logic [1:0] m);
        case (m)
            2'd0:    return 2'd2;
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Drive one request at a falling edge, then check the results at the next falling edge.
    task automatic issue(input string req, input logic [1:0] m, input logic [7:0] x,
                         input logic [7:0] b0, input logic [7:0] b1);
        mode = m; index_reg = x; opnd0 = b0; opnd1 = b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req, 32'(ea), 32'(model_ea(m, x, b0, b1)));
        check(req, 32'(ilen), 32'(model_len(m)));
        check({req, " valid"}, 32'(valid), 32'd1);
    endtask

    task automatic t_reset;
        check("R8 valid", 32'(valid), 0);
        check("R8 ea", 32'(ea), 0);
        check("R8 ilen", 32'(ilen), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 valid after release", 32'(valid), 0);
        check("R8 ea after release", 32'(ea), 0);
    endtask

    task automatic t_direct;
        issue("R1 direct 5A", 2'd0, 8'h33, 8'h5A, 8'hC3);
        issue("R1 direct FF", 2'd0, 8'hFF, 8'hFF, 8'hFF);
    endtask

    task automatic t_bare;
        issue("R2 bare 00", 2'd1, 8'h00, 8'h12, 8'h34);
        issue("R2 bare FF", 2'd1, 8'hFF, 8'hAB, 8'hCD);
    endtask

    task automatic t_short;
        issue("R3 short 10+20", 2'd2, 8'h10, 8'h20, 8'h99);
        issue("R3 short carry", 2'd2, 8'h80, 8'h80, 8'h00);
        issue("R3 short max 1FE", 2'd2, 8'hFF, 8'hFF, 8'hFF);
    endtask

    task automatic t_long;
        issue("R4 long 1234+05", 2'd3, 8'h05, 8'h12, 8'h34);
        issue("R4 long carry byte", 2'd3, 8'hFF, 8'hA0, 8'h01);
    endtask

    task automatic t_wrap;
        issue("R5 wrap FFFF+FF", 2'd3, 8'hFF, 8'hFF, 8'hFF);
        issue("R5 wrap FF01+FF", 2'd3, 8'hFF, 8'hFF, 8'h01);
    endtask

    task automatic t_valid;
        @(negedge clk);
        check("R6 idle valid low", 32'(valid), 0);
        mode = 2'd1; index_reg = 8'h11; start = 1'b1;
        @(negedge clk);
        check("R6 first valid", 32'(valid), 1);
        check("R6 first ea", 32'(ea), 32'h11);
        index_reg = 8'h22;
        @(negedge clk);
        check("R6 second valid", 32'(valid), 1);
        check("R6 second ea", 32'(ea), 32'h22);
        start = 1'b0;
        @(negedge clk);
        check("R6 valid drops", 32'(valid), 0);
    endtask

    task automatic t_hold;
        issue("R7 setup", 2'd3, 8'h01, 8'h40, 8'h00);
        mode = 2'd0; index_reg = 8'hEE; opnd0 = 8'h77; opnd1 = 8'h66;
        @(negedge clk);
        check("R7 ea held", 32'(ea), 32'h4001);
        check("R7 ilen held", 32'(ilen), 32'd3);
        check("R7 valid low", 32'(valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_direct();
        t_bare();
        t_short();
        t_long();
        t_wrap();
        t_valid();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule